// File: doc/BRIEF.md
# Constrained Power-of-Two Clock Divider Bank

The block derives six related clock-enable streams from one parent clock: peripheral, display, CPU, coprocessor, coprocessor MMU and traffic controller. Each domain owns a 2-bit exponent in a 16-bit control word. A domain with exponent e produces a single-cycle enable strobe once every 2^e parent cycles, so the ratios available are 1, 2, 4 and 8.

Software writes the whole control word in one go. Before storing it, the block rewrites the exponent fields so that the relative frequency rules between domains always hold:

- The MMU clock is clamped to the coprocessor clock or half of it.
- The traffic controller is never faster than the CPU or the MMU.
- The display and peripheral domains are never faster than the traffic controller.

The corrected word is readable straight away. The dividers switch to it only at a point where every domain counter wraps together, so no strobe is ever cut short. Absolute frequency limits are not checked.

Top module: `pdiv_bank`

## Requirements
- R1: After a synchronous active-low reset, the read value is 0x0000 and every domain strobe (dom_tick) is high on every cycle, since all exponents are zero.
- R2: Bits 15:12 of a written word are stored and read back unchanged, whatever the exponent fields hold.
- R3: Field positions are peripheral [1:0], display [3:2], CPU [5:4], coprocessor [7:6], traffic controller [9:8] and MMU [11:10]. The stored MMU exponent is the written value clamped into the range from the coprocessor exponent to the coprocessor exponent plus one.
- R4: The stored traffic-controller exponent is the largest of three values: its written value, the CPU exponent and the already corrected MMU exponent.
- R5: The stored display and peripheral exponents are each the larger of their written value and the corrected traffic-controller exponent. A written value that already complies is kept.
- R6: The CPU and coprocessor exponents are stored exactly as written.
- R7: While a setting is active, domain i strobes exactly once every 2^e parent cycles. Here e is the active exponent of that domain, and dom_tick bit i belongs to field i in the order of R3.
- R8: The corrected word reads back on rd_data one cycle after the write. The dividers adopt the newest stored word only on a cycle where every domain counter is at its final count. Until then, the previous ratios continue without disturbance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parent clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to be corrected and stored |
| rd_data | output | 16 | Corrected stored control word |
| dom_tick | output | 6 | One enable strobe per domain, indexed as in R3 |

## Verification
The assertions assume the following about the inputs:
- rst_n and wr_en are driven synchronously.
- wr_data may hold any 16-bit pattern, because the correction must cope with every combination of exponents.

The stimulus drives inputs only on the falling edge and mixes the following:
- directed words that trigger each clamp on its own;
- fully random words written at random spacings, so that writes land both on and between the common wrap points.

A write landing exactly on a wrap cycle must be adopted immediately. The bench's reference model follows that rule as well, so the two stay in step.

// File: rtl/pdiv_pkg.sv
// pdiv_pkg: shared sizes and domain indices for the divider bank.
// Assumes six domains, each with an exponent field of EXP_W bits packed from bit 0 upward.
package pdiv_pkg;
    localparam int EXP_W    = 2;
    localparam int NUM_DOM  = 6;
    localparam int CTRL_W   = 16;

    // Domain index equals field slot: field i occupies bits [i*EXP_W +: EXP_W].
    localparam int IDX_PER  = 0;
    localparam int IDX_DISP = 1;
    localparam int IDX_CPU  = 2;
    localparam int IDX_COP  = 3;
    localparam int IDX_TC   = 4;
    localparam int IDX_MMU  = 5;
endpackage

// File: rtl/pdiv_ratio_fix.sv
// pdiv_ratio_fix: combinational correction of a raw control word.
// Applies, in order: MMU clamp to [cop, cop+1], traffic-controller raise,
// then display/peripheral raise. Bits above the exponent fields pass through.
// Assumes CTRL_W >= NUM_DOM*EXP_W.
module pdiv_ratio_fix
    import pdiv_pkg::*;
#(
    parameter int P_EXP_W  = EXP_W,
    parameter int P_CTRL_W = CTRL_W
) (
    input  logic [P_CTRL_W-1:0] raw_i,
    output logic [P_CTRL_W-1:0] fixed_o
);
    localparam int WW = P_EXP_W + 1;

    logic [WW-1:0] e_per, e_disp, e_cpu, e_cop, e_tc, e_mmu;
    logic [WW-1:0] cop_plus1;
    logic [WW-1:0] mmu_fix, tc_fix, disp_fix, per_fix;

    // Extract each field one bit wider, so that cop+1 cannot overflow.
    always_comb begin
        e_per  = {1'b0, raw_i[IDX_PER *P_EXP_W +: P_EXP_W]};
        e_disp = {1'b0, raw_i[IDX_DISP*P_EXP_W +: P_EXP_W]};
        e_cpu  = {1'b0, raw_i[IDX_CPU *P_EXP_W +: P_EXP_W]};
        e_cop  = {1'b0, raw_i[IDX_COP *P_EXP_W +: P_EXP_W]};
        e_tc   = {1'b0, raw_i[IDX_TC  *P_EXP_W +: P_EXP_W]};
        e_mmu  = {1'b0, raw_i[IDX_MMU *P_EXP_W +: P_EXP_W]};
        cop_plus1 = e_cop + WW'(1);
    end

    // Stage 1: clamp the MMU exponent into the window [cop, cop+1].
    always_comb begin
        mmu_fix = e_mmu;
        if (mmu_fix < e_cop)     mmu_fix = e_cop;
        if (mmu_fix > cop_plus1) mmu_fix = cop_plus1;
    end

    // Stage 2: raise the traffic controller to the CPU and corrected MMU exponents.
    always_comb begin
        tc_fix = e_tc;
        if (tc_fix < e_cpu)   tc_fix = e_cpu;
        if (tc_fix < mmu_fix) tc_fix = mmu_fix;
    end

    // Stage 3: raise display and peripheral to the corrected traffic controller.
    always_comb begin
        disp_fix = (e_disp < tc_fix) ? tc_fix : e_disp;
        per_fix  = (e_per  < tc_fix) ? tc_fix : e_per;
    end

    // Reassemble the word: untouched upper bits, corrected fields below.
    always_comb begin
        fixed_o = raw_i;
        fixed_o[IDX_PER *P_EXP_W +: P_EXP_W] = per_fix[P_EXP_W-1:0];
        fixed_o[IDX_DISP*P_EXP_W +: P_EXP_W] = disp_fix[P_EXP_W-1:0];
        fixed_o[IDX_TC  *P_EXP_W +: P_EXP_W] = tc_fix[P_EXP_W-1:0];
        fixed_o[IDX_MMU *P_EXP_W +: P_EXP_W] = mmu_fix[P_EXP_W-1:0];
    end
endmodule

// File: rtl/pdiv_ctrl_reg.sv
// pdiv_ctrl_reg: holds the corrected word for readback (shadow), and the
// word that drives the dividers (active). Active is reloaded from the newest
// word only on a common-wrap cycle. Assumes boundary_i is high only when
// every divider counter is at its final count.
module pdiv_ctrl_reg #(
    parameter int P_CTRL_W = pdiv_pkg::CTRL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [P_CTRL_W-1:0] fixed_i,
    input  logic                boundary_i,
    output logic [P_CTRL_W-1:0] shadow_o,
    output logic [P_CTRL_W-1:0] active_o
);
    // Shadow register: captures every corrected write.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow_o <= '0;
        else if (wr_en) shadow_o <= fixed_i;
    end

    // Active register: adopts the newest word at a common wrap; a same-cycle write wins.
    always_ff @(posedge clk) begin
        if (!rst_n)          active_o <= '0;
        else if (boundary_i) active_o <= wr_en ? fixed_i : shadow_o;
    end

    assert_hold_off_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary_i |=> $stable(active_o));

    assert_readback_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (shadow_o == $past(fixed_i)));
endmodule

// File: rtl/pdiv_dom_div.sv
// pdiv_dom_div: one power-of-two divider. Counts 0 .. 2^exp-1 and strobes at
// count zero. Assumes exp_i changes only on a cycle where at_last_o is high.
module pdiv_dom_div #(
    parameter int P_EXP_W = pdiv_pkg::EXP_W,
    parameter int P_CNT_W = (1 << P_EXP_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [P_EXP_W-1:0] exp_i,
    output logic               tick_o,
    output logic               at_last_o
);
    logic [P_CNT_W-1:0] cnt;
    logic [P_CNT_W-1:0] last_val;

    // Final count 2^exp-1; for the largest exp the shift wraps to zero, leaving all ones.
    assign last_val  = (P_CNT_W'(1) << exp_i) - P_CNT_W'(1);
    assign at_last_o = (cnt == last_val);
    assign tick_o    = (cnt == '0);

    // Divide counter: wraps to zero after the final count.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (at_last_o) cnt <= '0;
        else                cnt <= cnt + P_CNT_W'(1);
    end

    assert_cnt_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last_val);

    assert_tick_after_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        at_last_o |=> tick_o);
endmodule

// File: rtl/pdiv_bank.sv
// pdiv_bank: constrained power-of-two clock divider bank, top level.
// Corrects written control words, exposes the corrected word, and drives one
// divider per domain. A new setting is adopted only when every counter wraps
// together. Assumes synchronous rst_n and wr_en.
module pdiv_bank
    import pdiv_pkg::*;
#(
    parameter int P_EXP_W  = EXP_W,
    parameter int P_CTRL_W = CTRL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [P_CTRL_W-1:0] wr_data,
    output logic [P_CTRL_W-1:0] rd_data,
    output logic [NUM_DOM-1:0]  dom_tick
);
    localparam int FIELD_BITS = NUM_DOM * P_EXP_W;
    localparam int CNT_W      = (1 << P_EXP_W) - 1;

    logic [P_CTRL_W-1:0] fixed_word;
    logic [P_CTRL_W-1:0] active_word;
    logic [NUM_DOM-1:0]  at_last;
    logic                boundary;

    // Common wrap: every domain counter at its final count in the same cycle.
    assign boundary = &at_last;

    pdiv_ratio_fix #(.P_EXP_W(P_EXP_W), .P_CTRL_W(P_CTRL_W)) u_fix (
        .raw_i   (wr_data),
        .fixed_o (fixed_word)
    );

    pdiv_ctrl_reg #(.P_CTRL_W(P_CTRL_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .fixed_i    (fixed_word),
        .boundary_i (boundary),
        .shadow_o   (rd_data),
        .active_o   (active_word)
    );

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        pdiv_dom_div #(.P_EXP_W(P_EXP_W), .P_CNT_W(CNT_W)) u_div (
            .clk       (clk),
            .rst_n     (rst_n),
            .exp_i     (active_word[d*P_EXP_W +: P_EXP_W]),
            .tick_o    (dom_tick[d]),
            .at_last_o (at_last[d])
        );
    end

    assert_mmu_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[IDX_MMU*P_EXP_W +: P_EXP_W] >= rd_data[IDX_COP*P_EXP_W +: P_EXP_W]);

    assert_mmu_ceiling_R3: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, rd_data[IDX_MMU*P_EXP_W +: P_EXP_W]} <=
        ({1'b0, rd_data[IDX_COP*P_EXP_W +: P_EXP_W]} + (P_EXP_W+1)'(1)));

    assert_tc_slowest_core_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[IDX_TC*P_EXP_W +: P_EXP_W] >= rd_data[IDX_CPU*P_EXP_W +: P_EXP_W]) &&
        (rd_data[IDX_TC*P_EXP_W +: P_EXP_W] >= rd_data[IDX_MMU*P_EXP_W +: P_EXP_W]));

    assert_periph_below_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[IDX_DISP*P_EXP_W +: P_EXP_W] >= rd_data[IDX_TC*P_EXP_W +: P_EXP_W]) &&
        (rd_data[IDX_PER *P_EXP_W +: P_EXP_W] >= rd_data[IDX_TC*P_EXP_W +: P_EXP_W]));

    assert_upper_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[P_CTRL_W-1:FIELD_BITS] == $past(wr_data[P_CTRL_W-1:FIELD_BITS])));

    assert_core_fields_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[IDX_CPU*P_EXP_W +: P_EXP_W] == $past(wr_data[IDX_CPU*P_EXP_W +: P_EXP_W])) &&
                  (rd_data[IDX_COP*P_EXP_W +: P_EXP_W] == $past(wr_data[IDX_COP*P_EXP_W +: P_EXP_W])));
endmodule

// File: tb/sim_pdiv_bank.sv
`timescale 1ns/1ps
// sim_pdiv_bank: self-checking bench with a behavioural reference model
// compared on every clock, plus directed and random checks.
module sim_pdiv_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = 16'h0;
    logic [15:0] rd_data;
    logic [5:0]  dom_tick;

    int checks = 0;
    int errors = 0;
    bit model_on = 0;
    bit finished = 0;

    // Model state
    int m_shadow = 0;
    int m_active [6];
    int m_cnt    [6];

    always #2.5 clk = ~clk;

    pdiv_bank u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .dom_tick(dom_tick)
    );

    // Expected corrected word, derived from R2..R6.
    function automatic int fix_word(int raw);
        int f [6];
        int res;
        for (int i = 0; i < 6; i++) f[i] = (raw >> (2*i)) & 3;
        if (f[5] < f[3])     f[5] = f[3];
        if (f[5] > f[3] + 1) f[5] = f[3] + 1;
        if (f[4] < f[2])     f[4] = f[2];
        if (f[4] < f[5])     f[4] = f[5];
        if (f[1] < f[4])     f[1] = f[4];
        if (f[0] < f[4])     f[0] = f[4];
        res = raw & 16'hF000;
        for (int i = 0; i < 6; i++) res = res | (f[i] << (2*i));
        return res;
    endfunction

    // Reference model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_shadow = 0;
            for (int d = 0; d < 6; d++) begin m_active[d] = 0; m_cnt[d] = 0; end
        end else begin
            bit bnd;
            int nw;
            bnd = 1;
            for (int d = 0; d < 6; d++)
                if (m_cnt[d] != (1 << m_active[d]) - 1) bnd = 0;
            for (int d = 0; d < 6; d++)
                m_cnt[d] = (m_cnt[d] == (1 << m_active[d]) - 1) ? 0 : m_cnt[d] + 1;
            nw = wr_en ? fix_word(int'(wr_data)) : m_shadow;
            if (bnd)
                for (int d = 0; d < 6; d++) m_active[d] = (nw >> (2*d)) & 3;
            if (wr_en) m_shadow = fix_word(int'(wr_data));
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (model_on && !finished) begin
            checks++;
            if (int'(rd_data) != m_shadow) begin
                errors++;
                $display("FAIL R8 readback: got %h expected %h", rd_data, m_shadow[15:0]);
            end
            for (int d = 0; d < 6; d++) begin
                checks++;
                if (dom_tick[d] != (m_cnt[d] == 0)) begin
                    errors++;
                    $display("FAIL R7 tick domain %0d: got %b expected %b", d, dom_tick[d], m_cnt[d] == 0);
                end
            end
        end
    end

    task automatic check_eq(string tag, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic write_word(input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic check_rules(string tag);
        int f [6];
        for (int i = 0; i < 6; i++) f[i] = (int'(rd_data) >> (2*i)) & 3;
        check_eq({tag, " R3 mmu window"}, int'(f[5] >= f[3] && f[5] <= f[3] + 1), 1);
        check_eq({tag, " R4 tc slowest"}, int'(f[4] >= f[2] && f[4] >= f[5]), 1);
        check_eq({tag, " R5 periph below tc"}, int'(f[1] >= f[4] && f[0] >= f[4]), 1);
    endtask

    // Count strobes per domain over 64 cycles once the setting is in force (R7).
    task automatic check_spacing(int word);
        int cnt [6];
        repeat (16) @(negedge clk);
        for (int d = 0; d < 6; d++) cnt[d] = 0;
        repeat (64) begin
            @(negedge clk);
            for (int d = 0; d < 6; d++) if (dom_tick[d]) cnt[d]++;
        end
        for (int d = 0; d < 6; d++)
            check_eq($sformatf("R7 spacing domain %0d", d), cnt[d], 64 >> ((word >> (2*d)) & 3));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1;
        @(negedge clk);
        check_eq("R1 reset readback", int'(rd_data), 0);
        check_eq("R1 reset ticks", int'(dom_tick), 6'h3F);
        @(negedge clk);
        check_eq("R1 reset ticks next cycle", int'(dom_tick), 6'h3F);

        write_word(16'hA000); check_eq("R2 upper bits", int'(rd_data), 16'hA000);
        write_word(16'h0C00); check_eq("R3 mmu clamp down", int'(rd_data), 16'h0505);
        write_word(16'h0080); check_eq("R3 mmu raise with R6 cop kept", int'(rd_data), 16'h0A8A);
        write_word(16'h0030); check_eq("R4 tc follows cpu", int'(rd_data), 16'h033F);
        check_spacing(16'h033F);
        write_word(16'h010B); check_eq("R5 compliant kept", int'(rd_data), 16'h010B);
        write_word(16'h0200); check_eq("R5 raise to tc", int'(rd_data), 16'h020A);
        check_spacing(16'h020A);
        write_word(16'hFFFF); check_eq("R6 all max", int'(rd_data), 16'hFFFF);
        check_spacing(16'hFFFF);

        // R8: change mid-period; old ratios must persist until the common wrap.
        @(negedge clk);
        while (!dom_tick[0]) @(negedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 16'h0000;
        @(negedge clk);
        wr_en = 1'b0;
        check_eq("R8 readback before apply", int'(rd_data), 0);
        check_eq("R8 old ratio still held", int'(dom_tick), 0);
        check_spacing(16'h0000);

        // Random writes at random spacings, rules checked on each readback.
        for (int k = 0; k < 60; k++) begin
            logic [15:0] v;
            v = 16'($urandom);
            write_word(v);
            check_eq("R8 random readback", int'(rd_data), fix_word(int'(v)));
            check_rules("random");
            repeat ($urandom_range(0, 20)) @(negedge clk);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule